// File: doc/BRIEF.md
# 16-bit Logic and Rotate Unit

This block is the word-wide logic and shift slice of an 8-bit processor that also executes a set of 16-bit register instructions. Each clock it takes two operand words, an incoming carry and a 3-bit operation code. One cycle later it presents the result word and four flags: sign, zero, parity/overflow and carry. The five operations are bitwise AND, bitwise OR, boolean normalise (any nonzero word becomes 1), rotate right through carry and rotate left through carry.

Flags never keep their old state. Each operation starts from an all-clear flag set and then sets only the flags it defines. Parity is taken over the whole word, not over a byte. Register file access, instruction decode and add/subtract arithmetic sit outside this block. The caller feeds the operands and takes the result and flags back into its own registers.

Top module: `lr16_unit`

## Requirements
- R1: Operation code 3'd0 gives `op_a & op_b` and code 3'd1 gives `op_a | op_b` on `result`.
- R2: For codes 0, 1, 3 and 4, `flag_s` equals result bit 15 and `flag_z` is 1 exactly when the 16-bit result is zero.
- R3: For codes 0, 1, 3 and 4, `flag_pv` is 1 exactly when the 16-bit result holds an even number of one bits.
- R4: Code 3'd2 (boolean) gives 16'h0001 for a nonzero `op_a` and 16'h0000 for a zero `op_a`. `flag_z` is set only for the zero case, and `flag_s`, `flag_pv` and `flag_c` are 0.
- R5: Code 3'd3 (rotate right through carry) gives `{carry_in, op_a[15:1]}` with `flag_c` = `op_a[0]`.
- R6: Code 3'd4 (rotate left through carry) gives `{op_a[14:0], carry_in}` with `flag_c` = `op_a[15]`.
- R7: Codes 0 and 1 always drive `flag_c` to 0, whatever `carry_in` is.
- R8: Codes 3'd5, 3'd6 and 3'd7 pass `op_a` to `result` with all four flags 0.
- R9: Outputs appear on the first rising clock edge after the inputs are applied. While `rst_n` is low, `result` and all flags are 0.
- R10: `op_b` has no effect on the outputs for codes 2 to 7, and `carry_in` has no effect for codes 0, 1, 2 and 5 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | W (16) | First operand, the source for boolean, rotate and pass |
| op_b | input | W (16) | Second operand, used only by AND and OR |
| carry_in | input | 1 | Incoming carry, used by the rotates |
| op_sel | input | 3 | Operation code |
| result | output | W (16) | Registered result word |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_pv | output | 1 | Parity flag, set on even population |
| flag_c | output | 1 | Carry flag |

## Verification
The bench builds the unit at its default width of 16. At that width the word-wide corners can be driven directly: 16'h8000 and 16'h0001 for the rotate carry-out, 16'hFFFF for even parity of a full word, and a word whose two bytes have odd parity each but whose whole-word parity is even. A behavioural model in the bench predicts every result and flag set for random operands under all eight codes. It also covers directed cases where only `op_b` or `carry_in` changes, which shows the unused input is ignored.

// File: rtl/lr16_pkg.sv
package lr16_pkg;

    // operation codes (3-bit select)
    localparam logic [2:0] OPC_AND  = 3'd0;
    localparam logic [2:0] OPC_OR   = 3'd1;
    localparam logic [2:0] OPC_BOOL = 3'd2;
    localparam logic [2:0] OPC_RRC  = 3'd3;
    localparam logic [2:0] OPC_RLC  = 3'd4;

    // number of result candidates that carry word-derived flags
    localparam int NCAND = 4;
    localparam int CAND_AND = 0;
    localparam int CAND_OR  = 1;
    localparam int CAND_RRC = 2;
    localparam int CAND_RLC = 3;

    typedef struct packed {
        logic s;
        logic z;
        logic pv;
        logic c;
    } flags_t;

    localparam flags_t FLAGS_CLEAR = '{s: 1'b0, z: 1'b0, pv: 1'b0, c: 1'b0};

endpackage

// File: rtl/lr16_logic.sv
module lr16_logic #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] and_w,
    output logic [W-1:0] or_w,
    output logic [W-1:0] bool_w
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    assign and_w  = a & b;
    assign or_w   = a | b;
    assign bool_w = (|a) ? ONE : '0;

endmodule

// File: rtl/lr16_rotate.sv
module lr16_rotate #(
    parameter int W    = 16,
    parameter bit LEFT = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] rot_w,
    output logic         cout
);
    localparam int MSB = W - 1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (LEFT) begin : g_left
            if (i == 0) begin : g_lsb
                assign rot_w[i] = cin;
            end else begin : g_mid
                assign rot_w[i] = a[i-1];
            end
        end else begin : g_right
            if (i == MSB) begin : g_msb
                assign rot_w[i] = cin;
            end else begin : g_mid
                assign rot_w[i] = a[i+1];
            end
        end
    end

    if (LEFT) begin : g_cout_l
        assign cout = a[MSB];
    end else begin : g_cout_r
        assign cout = a[0];
    end

endmodule

// File: rtl/lr16_flags.sv
module lr16_flags #(
    parameter int W = 16
) (
    input  logic [W-1:0] v,
    output logic         sign,
    output logic         zero,
    output logic         par_even
);
    localparam int MSB = W - 1;

    logic [W-1:0] chain;

    assign chain[0] = v[0];
    for (genvar i = 1; i < W; i++) begin : g_par
        assign chain[i] = chain[i-1] ^ v[i];
    end

    assign sign     = v[MSB];
    assign zero     = ~(|v);
    assign par_even = ~chain[MSB];

endmodule

// File: rtl/lr16_unit.sv
module lr16_unit
    import lr16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         carry_in,
    input  logic [2:0]   op_sel,
    output logic [W-1:0] result,
    output logic         flag_s,
    output logic         flag_z,
    output logic         flag_pv,
    output logic         flag_c
);
    typedef struct packed {
        logic [W-1:0] res;
        flags_t       fl;
    } state_t;

    state_t st_d, st_q;

    logic [W-1:0] and_w, or_w, bool_w;
    logic [W-1:0] rot_w  [2];
    logic         rot_c  [2];
    logic [W-1:0] cand_w [NCAND];
    logic         cand_s [NCAND];
    logic         cand_z [NCAND];
    logic         cand_p [NCAND];

    lr16_logic #(.W(W)) u_logic (
        .a      (op_a),
        .b      (op_b),
        .and_w  (and_w),
        .or_w   (or_w),
        .bool_w (bool_w)
    );

    // index 0: rotate right, index 1: rotate left
    for (genvar d = 0; d < 2; d++) begin : g_rot
        lr16_rotate #(.W(W), .LEFT(d == 1)) u_rot (
            .a     (op_a),
            .cin   (carry_in),
            .rot_w (rot_w[d]),
            .cout  (rot_c[d])
        );
    end

    assign cand_w[CAND_AND] = and_w;
    assign cand_w[CAND_OR]  = or_w;
    assign cand_w[CAND_RRC] = rot_w[0];
    assign cand_w[CAND_RLC] = rot_w[1];

    for (genvar k = 0; k < NCAND; k++) begin : g_flag
        lr16_flags #(.W(W)) u_flags (
            .v        (cand_w[k]),
            .sign     (cand_s[k]),
            .zero     (cand_z[k]),
            .par_even (cand_p[k])
        );
    end

    // next-state computation: flags start clear, then the op sets its own
    always_comb begin
        st_d     = '0;
        st_d.fl  = FLAGS_CLEAR;
        st_d.res = op_a;
        case (op_sel)
            OPC_AND: begin
                st_d.res   = cand_w[CAND_AND];
                st_d.fl.s  = cand_s[CAND_AND];
                st_d.fl.z  = cand_z[CAND_AND];
                st_d.fl.pv = cand_p[CAND_AND];
            end
            OPC_OR: begin
                st_d.res   = cand_w[CAND_OR];
                st_d.fl.s  = cand_s[CAND_OR];
                st_d.fl.z  = cand_z[CAND_OR];
                st_d.fl.pv = cand_p[CAND_OR];
            end
            OPC_BOOL: begin
                st_d.res  = bool_w;
                st_d.fl.z = ~(|op_a);
            end
            OPC_RRC: begin
                st_d.res   = cand_w[CAND_RRC];
                st_d.fl.s  = cand_s[CAND_RRC];
                st_d.fl.z  = cand_z[CAND_RRC];
                st_d.fl.pv = cand_p[CAND_RRC];
                st_d.fl.c  = rot_c[0];
            end
            OPC_RLC: begin
                st_d.res   = cand_w[CAND_RLC];
                st_d.fl.s  = cand_s[CAND_RLC];
                st_d.fl.z  = cand_z[CAND_RLC];
                st_d.fl.pv = cand_p[CAND_RLC];
                st_d.fl.c  = rot_c[1];
            end
            default: begin
                st_d.res = op_a;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result  = st_q.res;
    assign flag_s  = st_q.fl.s;
    assign flag_z  = st_q.fl.z;
    assign flag_pv = st_q.fl.pv;
    assign flag_c  = st_q.fl.c;

endmodule

// File: rtl/lr16_unit_chk.sv
module lr16_unit_chk
    import lr16_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         carry_in,
    input logic [2:0]   op_sel,
    input logic [W-1:0] result,
    input logic         flag_s,
    input logic         flag_z,
    input logic         flag_pv,
    input logic         flag_c
);
    localparam int MSB = W - 1;

    // set once a clock edge has passed outside reset
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    logic word_op;
    assign word_op = (op_sel == OPC_AND) || (op_sel == OPC_OR) ||
                     (op_sel == OPC_RRC) || (op_sel == OPC_RLC);

    AST_AND_OR_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(op_sel) == OPC_AND |-> result == ($past(op_a) & $past(op_b))); // R1

    AST_OR_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(op_sel) == OPC_OR |-> result == ($past(op_a) | $past(op_b))); // R1

    AST_SIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(word_op) |-> flag_s == result[MSB] && flag_z == (result == '0)); // R2

    AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(word_op) |-> flag_pv == ($countones(result) % 2 == 0)); // R3

    AST_BOOL_NORM: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(op_sel) == OPC_BOOL |->
            result == (($past(op_a) != '0) ? W'(1) : W'(0)) &&
            flag_z == ($past(op_a) == '0) && !flag_s && !flag_pv && !flag_c); // R4

    AST_ROT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(op_sel) == OPC_RRC |->
            result[MSB] == $past(carry_in) && flag_c == $past(op_a[0])); // R5

    AST_ROT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(op_sel) == OPC_RLC |->
            result[0] == $past(carry_in) && flag_c == $past(op_a[MSB])); // R6

    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        armed && ($past(op_sel) == OPC_AND || $past(op_sel) == OPC_OR) |-> !flag_c); // R7

    AST_PASS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(op_sel) > OPC_RLC |->
            result == $past(op_a) && {flag_s, flag_z, flag_pv, flag_c} == 4'b0000); // R8

endmodule

bind lr16_unit lr16_unit_chk #(.W(W)) u_chk (.*);

// File: tb/lr16_unit_tb.sv
module lr16_unit_tb;
    localparam int W = 16;

    typedef struct {
        logic [W-1:0] res;
        logic         s, z, p, c;
        string        req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic         carry_in = 1'b0;
    logic [2:0]   op_sel = 3'd0;
    logic [W-1:0] result;
    logic         flag_s, flag_z, flag_pv, flag_c;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    lr16_unit #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .carry_in(carry_in), .op_sel(op_sel), .result(result),
        .flag_s(flag_s), .flag_z(flag_z), .flag_pv(flag_pv), .flag_c(flag_c)
    );

    // behavioural reference written from the requirements
    function automatic exp_t model(logic [W-1:0] a, logic [W-1:0] b,
                                   logic cin, logic [2:0] op, string req);
        exp_t e;
        int   ones;
        bit   word_flags;
        e.res = a; e.s = 0; e.z = 0; e.p = 0; e.c = 0; e.req = req;
        word_flags = 1'b0;
        case (op)
            3'd0: begin e.res = a & b; word_flags = 1'b1; end
            3'd1: begin e.res = a | b; word_flags = 1'b1; end
            3'd2: begin e.res = (a != 0) ? 16'h0001 : 16'h0000; e.z = (a == 0); end
            3'd3: begin e.res = {cin, a[W-1:1]}; e.c = a[0]; word_flags = 1'b1; end
            3'd4: begin e.res = {a[W-2:0], cin}; e.c = a[W-1]; word_flags = 1'b1; end
            default: e.res = a;
        endcase
        if (word_flags) begin
            ones = 0;
            for (int i = 0; i < W; i++) if (e.res[i]) ones++;
            e.s = e.res[W-1];
            e.z = (e.res == 0);
            e.p = (ones % 2 == 0);
        end
        return e;
    endfunction

    task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic cin,
                         logic [2:0] op, string req);
        @(negedge clk);
        op_a = a; op_b = b; carry_in = cin; op_sel = op;
        sb_q.push_back(model(a, b, cin, op, req));
    endtask

    // monitor: one result per edge, compared against the queue head
    always @(posedge clk) begin
        #2;
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            total++;
            if (result !== e.res || flag_s !== e.s || flag_z !== e.z ||
                flag_pv !== e.p || flag_c !== e.c) begin
                bad++;
                $display("FAIL %s: got res=%h s%0b z%0b p%0b c%0b exp res=%h s%0b z%0b p%0b c%0b",
                         e.req, result, flag_s, flag_z, flag_pv, flag_c,
                         e.res, e.s, e.z, e.p, e.c);
            end
        end
    end

    task automatic check_reset(string tag);
        total++;
        if (result !== '0 || {flag_s, flag_z, flag_pv, flag_c} !== 4'b0000) begin
            bad++;
            $display("FAIL %s: got res=%h flags=%b exp res=0000 flags=0000", tag,
                     result, {flag_s, flag_z, flag_pv, flag_c});
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog: got running exp finished");
        finish_run();
    end

    initial begin
        op_a = 16'hA5A5; op_b = 16'hFFFF; carry_in = 1'b1; op_sel = 3'd1;
        repeat (3) @(posedge clk);
        #2 check_reset("R9 reset");
        @(negedge clk) rst_n = 1'b1;

        // R1 / R2 / R3 / R7 logic ops
        drive(16'hF0F0, 16'h0FF0, 1'b1, 3'd0, "R1 and");
        drive(16'hF0F0, 16'h0F0F, 1'b1, 3'd0, "R2 and zero");
        drive(16'h8001, 16'h0000, 1'b1, 3'd1, "R2 or sign");
        drive(16'h0100, 16'h0001, 1'b0, 3'd1, "R3 whole-word parity");
        drive(16'hFFFF, 16'hFFFF, 1'b1, 3'd0, "R7 and carry 0");
        // R4 boolean
        drive(16'h0000, 16'h1234, 1'b1, 3'd2, "R4 bool zero");
        drive(16'h8000, 16'h0000, 1'b1, 3'd2, "R4 bool nonzero");
        // R5 / R6 rotates
        drive(16'h0001, 16'h0000, 1'b0, 3'd3, "R5 rrc carry out");
        drive(16'h8000, 16'h0000, 1'b1, 3'd3, "R5 rrc carry in");
        drive(16'h8000, 16'h0000, 1'b0, 3'd4, "R6 rlc carry out");
        drive(16'h0001, 16'h0000, 1'b1, 3'd4, "R6 rlc carry in");
        // R8 pass codes
        drive(16'hBEEF, 16'h0000, 1'b1, 3'd5, "R8 pass 5");
        drive(16'h0000, 16'hFFFF, 1'b1, 3'd6, "R8 pass 6");
        drive(16'h7FFF, 16'h1111, 1'b0, 3'd7, "R8 pass 7");
        // R10 ignored inputs: same op_a, other op_b / carry_in
        for (int op = 2; op < 8; op++) begin
            drive(16'hC3A1, 16'h0000, 1'b0, 3'(op), "R10 b ignored");
            drive(16'hC3A1, 16'hFFFF, 1'b0, 3'(op), "R10 b ignored");
        end
        drive(16'h5A5A, 16'h3C3C, 1'b0, 3'd0, "R10 cin ignored");
        drive(16'h5A5A, 16'h3C3C, 1'b1, 3'd0, "R10 cin ignored");
        drive(16'h5A5A, 16'h3C3C, 1'b1, 3'd2, "R10 cin ignored");
        drive(16'h5A5A, 16'h3C3C, 1'b1, 3'd6, "R10 cin ignored");

        // random sweep over all codes
        for (int n = 0; n < 4000; n++) begin
            drive(16'($urandom), 16'($urandom), 1'($urandom), 3'(n % 8), "R1 random sweep");
        end

        // R9 mid-run reset
        @(negedge clk);
        op_sel = 3'd5; op_a = 16'hFFFF;
        wait (sb_q.size() == 0);
        @(negedge clk) rst_n = 1'b0;
        #1 check_reset("R9 reset mid-run");
        @(negedge clk) rst_n = 1'b1;
        drive(16'h1234, 16'h0000, 1'b0, 3'd5, "R9 latency after reset");
        repeat (3) @(posedge clk);
        #3 finish_run();
    end

endmodule